// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Per-Pin Interrupt Triggers

This block is one bank of general-purpose I/O. Software configures it through a small synchronous register bus: each pin can be made an input or an output, given an output value, and handed to an alternate peripheral. The bank reports the sampled pin levels through a register. Every input passes through a two-flop synchroniser before any logic looks at it.

Each pin also has its own interrupt trigger. A per-pin select chooses edge or level detection. Separate polarity bits pick the rising or falling edge, or the active-high or active-low level. A detected event sets a sticky bit in the interrupt status register, and a write clears those bits. Bits written as zero are cleared, so a write of zero clears them all. The bank raises a single interrupt line while any status bit is set whose mask bit is clear. Several such banks are normally placed side by side at equally spaced base addresses, each with its own interrupt line.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, these values hold: direction 0x0000, output data 0x0000, alternate function 0x0000, mask 0xFFFF, trigger select 0x0000, edge polarity 0x0000, level polarity 0xFFFF, interrupt status 0x0000, and `irq` low.
- R2: Direction (bit 1 = output), output data and alternate function are read/write registers. They drive `pin_oe`, `pin_out` and `alt_sel` bit for bit, starting on the cycle after the write.
- R3: The pin-level register returns `pin_in` after two synchronising flops. A change on `pin_in` made between two clock edges reads back after the second following edge and not before.
- R4: When a pin's trigger select bit is 1 (edge), a status bit is set on a rising edge of the synchronised level if its edge polarity bit is 1, and on a falling edge if it is 0. An edge of the other direction sets nothing.
- R5: When a pin's trigger select bit is 0 (level), its status bit is set on every cycle that the synchronised level equals its level polarity bit (1 = active-high, 0 = active-low). Such a bit therefore reads 1 again right after a clear while the level stays active.
- R6: Status bits are sticky. A write to the interrupt status register clears each bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1.
- R7: When a detection event and a clearing write reach the same status bit on the same clock edge, the bit ends up set.
- R8: `irq` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks that pin.
- R9: Writes to the pin-level register have no effect on what it returns.
- R10: The register offsets on `bus_addr` are: 0 direction, 1 output data, 2 alternate function, 3 pin level (read-only), 4 mask, 5 trigger select, 6 edge polarity, 7 level polarity, 8 interrupt status. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Per-pin output enable |
| alt_sel | output | 16 | Per-pin alternate-function select |
| irq | output | 1 | Bank interrupt |

## Verification
The detection logic and a status-clearing write can act on the same status bit at the same clock edge. The bench provokes this in two ways. First, it changes a pin and times a write of zero so that the write is sampled on exactly the edge where the edge event lands, which is the third edge after the pin change. Second, it clears while a level-triggered pin is still active. In both cases it judges the result by reading the status register: the colliding bit must remain set and the other bits must be cleared. The random phase also changes pins on the same edge as a clear, and the expected status it computes includes the levels that are still active from before the change.

// File: rtl/gpio_bank_pkg.sv
// Package: gpio_bank_pkg
// Shared register offsets for the GPIO bank. Assumes a 4-bit offset bus.
package gpio_bank_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 4'd0,
        REG_DOUT  = 4'd1,
        REG_ALT   = 4'd2,
        REG_PINS  = 4'd3,
        REG_MASK  = 4'd4,
        REG_TRIG  = 4'd5,
        REG_EPOL  = 4'd6,
        REG_LPOL  = 4'd7,
        REG_ISTAT = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Synchroniser chain for W asynchronous inputs, STAGES flops deep.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the sampled level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Configuration registers of the bank and the read multiplexer.
// Assumes a single-cycle write strobe; reads are combinational on addr.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_lvl,
    input  logic [W-1:0]      istat,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      dout_q,
    output logic [W-1:0]      alt_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      trig_q,
    output logic [W-1:0]      epol_q,
    output logic [W-1:0]      lpol_q
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    // Purpose: reset and update the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            alt_q  <= '0;
            mask_q <= '1;
            trig_q <= '0;
            epol_q <= '0;
            lpol_q <= '1;
        end else if (we) begin
            case (sel)
                REG_DIR:  dir_q  <= wdata;
                REG_DOUT: dout_q <= wdata;
                REG_ALT:  alt_q  <= wdata;
                REG_MASK: mask_q <= wdata;
                REG_TRIG: trig_q <= wdata;
                REG_EPOL: epol_q <= wdata;
                REG_LPOL: lpol_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: select the register named by addr for the read port.
    always_comb begin
        case (sel)
            REG_DIR:   rdata = dir_q;
            REG_DOUT:  rdata = dout_q;
            REG_ALT:   rdata = alt_q;
            REG_PINS:  rdata = pin_lvl;
            REG_MASK:  rdata = mask_q;
            REG_TRIG:  rdata = trig_q;
            REG_EPOL:  rdata = epol_q;
            REG_LPOL:  rdata = lpol_q;
            REG_ISTAT: rdata = istat;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Per-pin edge/level detection and the sticky interrupt status register.
// Assumes pin_lvl is already synchronous to clk.
module gpio_irq_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_lvl,
    input  logic [W-1:0] trig,
    input  logic [W-1:0] epol,
    input  logic [W-1:0] lpol,
    input  logic         clr_we,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] evt,
    output logic [W-1:0] istat
);
    logic [W-1:0] prev;
    logic [W-1:0] rise, fall, edge_hit, lvl_hit, keep;

    // Purpose: hold the synchronised level from one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin_lvl;
    end

    // Purpose: qualify edges and levels by each pin's trigger settings.
    always_comb begin
        rise     = pin_lvl & ~prev;
        fall     = ~pin_lvl & prev;
        edge_hit = (epol & rise) | (~epol & fall);
        lvl_hit  = ~(pin_lvl ^ lpol);
        evt      = (trig & edge_hit) | (~trig & lvl_hit);
        keep     = clr_we ? clr_keep : '1;
    end

    // Purpose: sticky status; a new event overrides a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) istat <= '0;
        else        istat <= (istat & keep) | evt;
    end
endmodule

// File: rtl/gpio_bank_irq.sv
// Module: gpio_bank_irq
// One GPIO bank: synchroniser, register file, interrupt detection, irq OR.
// Assumes pin_in is asynchronous and bus writes are synchronous to clk.
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  alt_sel,
    output logic              irq
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] dir_q, dout_q, alt_q, mask_q, trig_q, epol_q, lpol_q;
    logic [NPINS-1:0] evt, istat;
    logic             istat_we;

    assign istat_we = bus_we && (reg_addr_e'(bus_addr) == REG_ISTAT);

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_regs #(.W(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_lvl (pin_sync),
        .istat   (istat),
        .rdata   (bus_rdata),
        .dir_q   (dir_q),
        .dout_q  (dout_q),
        .alt_q   (alt_q),
        .mask_q  (mask_q),
        .trig_q  (trig_q),
        .epol_q  (epol_q),
        .lpol_q  (lpol_q)
    );

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_sync),
        .trig     (trig_q),
        .epol     (epol_q),
        .lpol     (lpol_q),
        .clr_we   (istat_we),
        .clr_keep (bus_wdata),
        .evt      (evt),
        .istat    (istat)
    );

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
    assign alt_sel = alt_q;
    assign irq     = |(istat & ~mask_q);
endmodule

// File: rtl/gpio_bank_irq_chk.sv
// Module: gpio_bank_irq_chk
// Assertion checker bound into gpio_bank_irq.
module gpio_bank_irq_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_sync,
    input logic [NPINS-1:0]  trig_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  istat,
    input logic              irq
);
    logic wr_dir, wr_istat;
    assign wr_dir   = bus_we && (bus_addr == REG_DIR);
    assign wr_istat = bus_we && (bus_addr == REG_ISTAT);

    // R2: a direction write shows on pin_oe the next cycle.
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == $past(bus_wdata)));

    // R4: no edge event on edge pins while the synchronised level is unchanged.
    a_r4_no_edge_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pin_sync) |-> ((evt & trig_q) == '0));

    // R6: without a status write, no status bit falls.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_istat |=> ((istat & $past(istat)) == $past(istat)));

    // R6: a write of zero leaves only the bits of that cycle's events.
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_istat && bus_wdata == '0) |=> (istat == $past(evt)));

    // R7: every event is present in status on the next cycle.
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((istat & $past(evt)) == $past(evt)));

    // R8: a fully masked bank never interrupts.
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pin_sync  (pin_sync),
    .trig_q    (trig_q),
    .mask_q    (mask_q),
    .evt       (evt),
    .istat     (istat),
    .irq       (irq)
);

// File: tb/gpio_bank_irq_test.sv
`timescale 1ns/1ps
module gpio_bank_irq_test;
    localparam logic [3:0] A_DIR = 4'd0, A_DOUT = 4'd1, A_ALT = 4'd2, A_PINS = 4'd3,
                           A_MASK = 4'd4, A_TRIG = 4'd5, A_EPOL = 4'd6, A_LPOL = 4'd7,
                           A_ISTAT = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, alt_sel;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_irq uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected status after a pin change old->new made together with a clear.
    function automatic logic [15:0] exp_stat(input logic [15:0] trig, epol, lpol, oldv, newv);
        logic [15:0] lvl, edg;
        lvl = ~trig & (~(oldv ^ lpol) | ~(newv ^ lpol));
        edg = trig & ((epol & ~oldv & newv) | (~epol & oldv & ~newv));
        return lvl | edg;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5eed1234));
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        idle(4);

        // R1 reset values
        rd(A_DIR, v);   chk("R1 dir", v, 16'h0000);
        rd(A_DOUT, v);  chk("R1 dout", v, 16'h0000);
        rd(A_ALT, v);   chk("R1 alt", v, 16'h0000);
        rd(A_MASK, v);  chk("R1 mask", v, 16'hFFFF);
        rd(A_TRIG, v);  chk("R1 trig", v, 16'h0000);
        rd(A_EPOL, v);  chk("R1 epol", v, 16'h0000);
        rd(A_LPOL, v);  chk("R1 lpol", v, 16'hFFFF);
        rd(A_ISTAT, v); chk("R1 istat", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        chk("R1 pin_oe", pin_oe, 16'h0000);

        // R2 plain registers and their outputs
        wr(A_DIR, 16'hA5C3); chk("R2 pin_oe", pin_oe, 16'hA5C3);
        wr(A_DOUT, 16'h1234); chk("R2 pin_out", pin_out, 16'h1234);
        wr(A_ALT, 16'h0F0F); chk("R2 alt_sel", alt_sel, 16'h0F0F);
        rd(A_DIR, v); chk("R2 dir readback", v, 16'hA5C3);
        rd(A_ALT, v); chk("R2 alt readback", v, 16'h0F0F);

        // R10 unmapped offset
        rd(4'd15, v); chk("R10 unmapped reads 0", v, 16'h0000);

        // R3 synchroniser latency, rising edges on all pins
        wr(A_TRIG, 16'hFFFF);
        wr(A_EPOL, 16'hFFFF);
        @(negedge clk); pin_in = 16'hBEEF;
        @(negedge clk); #1 bus_addr = A_PINS; #0.5 chk("R3 one edge", bus_rdata, 16'h0000);
        @(negedge clk); #1 chk("R3 two edges", bus_rdata, 16'hBEEF);
        // R9 pin register read-only
        wr(A_PINS, 16'h0000);
        rd(A_PINS, v); chk("R9 pins write ignored", v, 16'hBEEF);
        rd(A_ISTAT, v); chk("R4 rising edges", v, 16'hBEEF);
        wr(A_ISTAT, 16'h0000);
        rd(A_ISTAT, v); chk("R6 clear by zero", v, 16'h0000);
        // R4 falling edge ignored with rising polarity
        @(negedge clk); pin_in = 16'h0000;
        idle(5);
        rd(A_ISTAT, v); chk("R4 falling ignored", v, 16'h0000);

        // R6 partial clear
        @(negedge clk); pin_in = 16'h1008;
        idle(5);
        rd(A_ISTAT, v); chk("R4 two rises", v, 16'h1008);
        wr(A_ISTAT, 16'hFFF0);
        rd(A_ISTAT, v); chk("R6 keep ones clear zeros", v, 16'h1000);
        wr(A_ISTAT, 16'h0000);
        @(negedge clk); pin_in = 16'h0000;
        idle(5);
        wr(A_ISTAT, 16'h0000);

        // R7 edge event landing on the clearing edge
        @(negedge clk); pin_in = 16'h0008;
        idle(5);
        rd(A_ISTAT, v); chk("R4 setup bit3", v, 16'h0008);
        @(negedge clk); pin_in = 16'h0028;
        @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = A_ISTAT; bus_wdata = 16'h0000;
        @(negedge clk); bus_we = 1'b0;
        rd(A_ISTAT, v); chk("R7 event beats clear", v, 16'h0020);

        // R8 masking
        chk("R8 masked no irq", {15'd0, irq}, 16'h0000);
        wr(A_MASK, 16'hFFDF);
        chk("R8 unmasked irq", {15'd0, irq}, 16'h0001);
        wr(A_MASK, 16'h0020);
        chk("R8 other unmasked no irq", {15'd0, irq}, 16'h0000);

        // R5 level re-set after clear (pin 5 high, active-high level)
        wr(A_TRIG, 16'hFFDF);
        wr(A_ISTAT, 16'h0000);
        rd(A_ISTAT, v); chk("R5 level sets again", v, 16'h0020);
        wr(A_LPOL, 16'hFFDF);
        wr(A_ISTAT, 16'h0000);
        rd(A_ISTAT, v); chk("R5 level inactive stays clear", v, 16'h0000);

        // Random phase: R4 R5 R6 R7 R8 under mixed configurations
        for (int it = 0; it < 40; it++) begin
            logic [15:0] t, ep, lp, m, o, n, e;
            t = 16'($urandom); ep = 16'($urandom); lp = 16'($urandom);
            m = 16'($urandom); o = 16'($urandom); n = 16'($urandom);
            wr(A_TRIG, t); wr(A_EPOL, ep); wr(A_LPOL, lp); wr(A_MASK, m);
            @(negedge clk); pin_in = o;
            idle(5);
            @(negedge clk); pin_in = n; bus_we = 1'b1; bus_addr = A_ISTAT; bus_wdata = 16'h0000;
            @(negedge clk); bus_we = 1'b0;
            idle(5);
            e = exp_stat(t, ep, lp, o, n);
            rd(A_ISTAT, v); chk("R4/R5 random status", v, e);
            rd(A_PINS, v);  chk("R3 random pins", v, n);
            chk("R8 random irq", {15'd0, irq}, {15'd0, |(e & ~m)});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule